// File: doc/BRIEF.md
# Vector Shift-by-Immediate Execution Unit

This unit performs one already-decoded shift-by-constant operation on a 128-bit vector. The vector is split into lanes of 8, 16, 32 or 64 bits. A caller presents the source vector, the current contents of the destination vector, a lane-size code, a shift count, a signedness flag, an operation mode, and rounding and accumulate flags. One cycle later the unit returns the new destination vector.

There are four operation modes:
- Right shift, which can optionally round and can optionally accumulate into the destination.
- Right shift with insert.
- Left shift with insert.
- Plain left shift.

The insert modes keep the destination bits that the shifted source does not cover. No lane ever passes a carry to its neighbour. When only a 64-bit register is involved, the caller uses the half of the result that it needs. The unit processes all lanes regardless.

Top module: `shimm_exec`

## Requirements
- R1: Lane size is coded by `lane_sz`: 0 means 8 bits, 1 means 16, 2 means 32 and 3 means 64. With `op_mode`=0 (right shift) and `rnd_en`=`acc_en`=0, each lane becomes its source lane shifted right by `sh_amt`, for counts from 1 up to the lane width. The shift is arithmetic when `in_signed`=1 and logical when it is 0.
- R2: A right shift by exactly the lane width gives 0 when logical. When arithmetic, it gives a lane filled with the source sign bit.
- R3: With `rnd_en`=1 in mode 0, the shifted lane is increased by 1 whenever bit `sh_amt`-1 of the original source lane is set.
- R4: With `acc_en`=1 in mode 0, the shifted lane (rounded if `rnd_en`=1) is added to the old destination lane, wrapping modulo 2^width, with no carry into the next lane.
- R5: In mode 1 (right insert), the mask is all-ones of the lane width shifted right by `sh_amt`. The result is (dst AND NOT mask) OR (src logically shifted right). When the count equals the lane width, the destination lane is returned unchanged.
- R6: In mode 2 (left insert), the mask is all-ones shifted left by `sh_amt`. The result is (dst AND NOT mask) OR (src shifted left), for counts from 0 up to the lane width minus 1.
- R7: In mode 3 (left shift), each lane becomes its source lane shifted left logically by `sh_amt`. The destination is ignored, and a count of 0 returns the source unchanged.
- R8: In modes 1, 2 and 3 the `rnd_en`, `acc_en` and `in_signed` inputs have no effect on the result.
- R9: `out_valid` rises in the cycle after `in_valid` and carries that operation's result in `out_data`. When `in_valid` is low, `out_valid` goes low and `out_data` holds its last value.
- R10: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src_vec | input | DW (128) | Source vector |
| dst_vec | input | DW (128) | Current destination vector |
| lane_sz | input | 2 | Lane size code (8/16/32/64 bits) |
| sh_amt | input | 7 | Shift count |
| in_signed | input | 1 | 1 = arithmetic right shift |
| op_mode | input | 2 | 0 right shift, 1 right insert, 2 left insert, 3 left shift |
| rnd_en | input | 1 | Round the right shift |
| acc_en | input | 1 | Accumulate into destination |
| out_valid | output | 1 | Result valid |
| out_data | output | DW (128) | New destination vector |

## Verification
The bench drives random vectors through every mode at every lane size, with counts drawn from the legal range of each mode. Comparing lane sizes separates the lane boundaries. Signed and unsigned runs on sources with their top bits set separate arithmetic shifts from logical ones. Directed cases cover the following:
- Right shifts by the full lane width.
- A right insert that must leave the destination untouched.
- Left shifts by zero.
- Rounding where the bit shifted out is set.
- Accumulation into all-ones destinations, which exposes any carry that leaks between lanes.
- Insert and left modes with the round, accumulate and sign flags toggled, which must give identical results.

// File: rtl/shimm_pkg.sv
package shimm_pkg;
  typedef enum logic [1:0] {
    M_RSHIFT = 2'd0,
    M_RINS   = 2'd1,
    M_LINS   = 2'd2,
    M_LSHIFT = 2'd3
  } mode_e;

  localparam int NUM_SIZES = 4;

  function automatic logic [6:0] lane_bits(input logic [1:0] code);
    return 7'd8 << code;
  endfunction
endpackage

// File: rtl/shimm_lane.sv
module shimm_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0]      src,
  input  logic [W-1:0]      dst,
  input  logic [6:0]        sh,
  input  shimm_pkg::mode_e  mode,
  input  logic              sgn,
  input  logic              rnd,
  input  logic              acc,
  output logic [W-1:0]      res
);
  import shimm_pkg::*;

  localparam logic [6:0] WL = 7'(W);

  logic           fill;
  logic [2*W-1:0] wide;
  logic [2*W-1:0] wsh;
  logic [W-1:0]   rsh;
  logic [W-1:0]   rtmp;
  logic           rbit;
  logic [W-1:0]   ones;
  logic [W-1:0]   mask_r;
  logic [W-1:0]   mask_l;

  always_comb begin
    fill   = sgn & src[W-1];
    wide   = {{W{fill}}, src};
    wsh    = wide >> sh;
    rsh    = wsh[W-1:0];
    rtmp   = src >> (sh - 7'd1);
    rbit   = rnd && (sh != 7'd0) && (sh <= WL) && rtmp[0];
    ones   = '1;
    mask_r = ones >> sh;
    mask_l = ones << sh;
    unique case (mode)
      M_RSHIFT: res = rsh + {{(W-1){1'b0}}, rbit} + (acc ? dst : {W{1'b0}});
      M_RINS:   res = (dst & ~mask_r) | (src >> sh);
      M_LINS:   res = (dst & ~mask_l) | (src << sh);
      default:  res = src << sh;
    endcase
  end
endmodule

// File: rtl/shimm_lane_array.sv
module shimm_lane_array #(
  parameter int DW = 128,
  parameter int W  = 8
) (
  input  logic [DW-1:0]     src,
  input  logic [DW-1:0]     dst,
  input  logic [6:0]        sh,
  input  shimm_pkg::mode_e  mode,
  input  logic              sgn,
  input  logic              rnd,
  input  logic              acc,
  output logic [DW-1:0]     res
);
  localparam int LANES = DW / W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    shimm_lane #(.W(W)) u_lane (
      .src  (src[i*W +: W]),
      .dst  (dst[i*W +: W]),
      .sh   (sh),
      .mode (mode),
      .sgn  (sgn),
      .rnd  (rnd),
      .acc  (acc),
      .res  (res[i*W +: W])
    );
  end
endmodule

// File: rtl/shimm_exec.sv
module shimm_exec #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] src_vec,
  input  logic [DW-1:0] dst_vec,
  input  logic [1:0]    lane_sz,
  input  logic [6:0]    sh_amt,
  input  logic          in_signed,
  input  logic [1:0]    op_mode,
  input  logic          rnd_en,
  input  logic          acc_en,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  import shimm_pkg::*;

  mode_e         mode;
  logic [DW-1:0] size_res [NUM_SIZES];
  logic [DW-1:0] next_data;

  assign mode = mode_e'(op_mode);

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    shimm_lane_array #(.DW(DW), .W(8 << g)) u_arr (
      .src  (src_vec),
      .dst  (dst_vec),
      .sh   (sh_amt),
      .mode (mode),
      .sgn  (in_signed),
      .rnd  (rnd_en),
      .acc  (acc_en),
      .res  (size_res[g])
    );
  end

  assign next_data = size_res[lane_sz];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) out_data <= next_data;
  end
endmodule

// File: rtl/shimm_exec_chk.sv
module shimm_exec_chk #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [DW-1:0] src_vec,
  input logic [DW-1:0] dst_vec,
  input logic [1:0]    lane_sz,
  input logic [6:0]    sh_amt,
  input logic          in_signed,
  input logic [1:0]    op_mode,
  input logic          rnd_en,
  input logic          acc_en,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  import shimm_pkg::*;

  a_r10_reset_clears: assert property (@(posedge clk) rst |=> !out_valid);

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r9_data_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  a_r5_full_insert_keeps: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_mode == 2'd1 && sh_amt == lane_bits(lane_sz))
    |=> out_data == $past(dst_vec));

  a_r7_zero_left_copies: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_mode == 2'd3 && sh_amt == 7'd0)
    |=> out_data == $past(src_vec));
endmodule

bind shimm_exec shimm_exec_chk #(.DW(DW)) u_chk (.*);

// File: tb/shimm_exec_tb.sv
module shimm_exec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 128;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [DW-1:0] src_vec, dst_vec;
  logic [1:0]    lane_sz;
  logic [6:0]    sh_amt;
  logic          in_signed;
  logic [1:0]    op_mode;
  logic          rnd_en, acc_en;
  logic          out_valid;
  logic [DW-1:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shimm_exec #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
    .dst_vec(dst_vec), .lane_sz(lane_sz), .sh_amt(sh_amt),
    .in_signed(in_signed), .op_mode(op_mode), .rnd_en(rnd_en),
    .acc_en(acc_en), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [DW-1:0] model(
    input logic [DW-1:0] s, input logic [DW-1:0] d, input logic [1:0] sz,
    input logic [6:0] sh, input logic sg, input logic [1:0] md,
    input logic rn, input logic ac);
    int w;
    logic [DW-1:0] out;
    w = 8 << sz;
    out = '0;
    for (int i = 0; i < DW / w; i++) begin
      logic [63:0] ones, a, dd, r, m;
      logic [127:0] wide;
      logic rb;
      ones = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
      a  = 64'(s >> (i * w)) & ones;
      dd = 64'(d >> (i * w)) & ones;
      case (md)
        2'd0: begin
          if (sg && a[w-1]) wide = {64'hFFFF_FFFF_FFFF_FFFF, a | ~ones};
          else              wide = {64'd0, a};
          r  = 64'(wide >> sh) & ones;
          rb = (sh != 0) && (((a >> (sh - 7'd1)) & 64'd1) != 0);
          if (rn && rb) r = r + 64'd1;
          if (ac) r = r + dd;
          r = r & ones;
        end
        2'd1: begin
          m = (ones >> sh) & ones;
          r = ((dd & ~m) | (a >> sh)) & ones;
        end
        2'd2: begin
          m = (ones << sh) & ones;
          r = ((dd & ~m) | (a << sh)) & ones;
        end
        default: r = (a << sh) & ones;
      endcase
      out = out | (DW'(r) << (i * w));
    end
    return out;
  endfunction

  function automatic logic [DW-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [DW-1:0] s, input logic [DW-1:0] d,
                        input logic [1:0] sz, input logic [6:0] sh, input logic sg,
                        input logic [1:0] md, input logic rn, input logic ac);
    @(negedge clk);
    in_valid = 1'b1; src_vec = s; dst_vec = d; lane_sz = sz; sh_amt = sh;
    in_signed = sg; op_mode = md; rnd_en = rn; acc_en = ac;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {127'd0, out_valid}, {127'd0, 1'b1});
    check(req, out_data, model(s, d, sz, sh, sg, md, rn, ac));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held, s0, d0, r0;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; src_vec = '0; dst_vec = '0; lane_sz = '0;
    sh_amt = '0; in_signed = 0; op_mode = '0; rnd_en = 0; acc_en = 0;
    repeat (3) @(negedge clk);
    check("R10 reset", {127'd0, out_valid}, 128'd0);
    rst = 1'b0;

    // Directed corner cases
    for (int sz = 0; sz < 4; sz++) begin
      logic [6:0] w;
      w = 7'd8 << sz;
      s0 = {32'h8000_00F1, 32'h7FFF_0000, 32'hFF80_8001, 32'h0123_89AB};
      d0 = {128{1'b1}};
      run_op("R2 full logical", s0, d0, 2'(sz), w, 1'b0, 2'd0, 1'b0, 1'b0);
      run_op("R2 full arith",   s0, d0, 2'(sz), w, 1'b1, 2'd0, 1'b0, 1'b0);
      run_op("R3 round full",   s0, d0, 2'(sz), w, 1'b1, 2'd0, 1'b1, 1'b0);
      run_op("R3 round by1",    {16{8'h03}}, d0, 2'(sz), 7'd1, 1'b0, 2'd0, 1'b1, 1'b0);
      run_op("R4 acc carry",    {128{1'b1}}, d0, 2'(sz), 7'd1, 1'b0, 2'd0, 1'b1, 1'b1);
      run_op("R5 insert full",  s0, 128'h5555_AAAA_1234_5678_9ABC_DEF0_0F0F_F0F0,
             2'(sz), w, 1'b0, 2'd1, 1'b0, 1'b0);
      run_op("R6 insert left",  s0, d0, 2'(sz), w - 7'd1, 1'b0, 2'd2, 1'b0, 1'b0);
      run_op("R7 left zero",    s0, d0, 2'(sz), 7'd0, 1'b0, 2'd3, 1'b0, 1'b0);
    end

    // R8: flags must not change insert/left results
    for (int k = 0; k < 24; k++) begin
      logic [1:0] md, sz;
      logic [6:0] sh;
      int w;
      md = 2'(1 + ($urandom % 3)); sz = 2'($urandom % 4); w = 8 << sz;
      sh = (md == 2'd1) ? 7'(1 + $urandom % w) : 7'($urandom % w);
      s0 = rnd128(); d0 = rnd128();
      run_op("R8 base", s0, d0, sz, sh, 1'b0, md, 1'b0, 1'b0);
      r0 = out_data;
      run_op("R8 flags", s0, d0, sz, sh, 1'b1, md, 1'b1, 1'b1);
      check("R8 unchanged", out_data, r0);
    end

    // R9: hold when idle
    run_op("R9 op", rnd128(), rnd128(), 2'd2, 7'd5, 1'b1, 2'd0, 1'b1, 1'b1);
    held = out_data;
    @(negedge clk);
    src_vec = rnd128(); dst_vec = rnd128(); op_mode = 2'd3; sh_amt = 7'd3;
    @(negedge clk);
    check("R9 idle valid", {127'd0, out_valid}, 128'd0);
    check("R9 hold", out_data, held);

    // Random mix, R1..R7
    for (int k = 0; k < 400; k++) begin
      logic [1:0] md, sz;
      logic [6:0] sh;
      logic sg, rn, ac;
      int w;
      md = 2'($urandom % 4); sz = 2'($urandom % 4); w = 8 << sz;
      sh = (md <= 2'd1) ? 7'(1 + $urandom % w) : 7'($urandom % w);
      sg = 1'($urandom); rn = 1'($urandom); ac = 1'($urandom);
      case (md)
        2'd0: run_op(rn ? (ac ? "R4 rnd acc" : "R3 rnd") : (ac ? "R4 acc" : "R1 shift"),
                     rnd128(), rnd128(), sz, sh, sg, md, rn, ac);
        2'd1: run_op("R5 rins", rnd128(), rnd128(), sz, sh, sg, md, rn, ac);
        2'd2: run_op("R6 lins", rnd128(), rnd128(), sz, sh, sg, md, rn, ac);
        default: run_op("R7 lshift", rnd128(), rnd128(), sz, sh, sg, md, rn, ac);
      endcase
    end

    // R10: reset mid-stream
    @(negedge clk);
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R10 reset with valid", {127'd0, out_valid}, 128'd0);
    rst = 1'b0; in_valid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule